// File: doc/BRIEF.md
# Microcoded Accumulator Processor Core

This block is a compact accumulator processor. A horizontal 16-bit control word, read from a built-in microcode store, drives every clock step. The core contains:

- a single shared 32-bit data bus;
- an accumulator with its ALU;
- a memory address register;
- an instruction register that holds the 24-bit immediate;
- a program counter;
- a micro-program counter.

Each control word enables at most one bus driver. It also says which registers capture from the bus, whether memory is written, and how the program counter moves. Some steps are instruction fetches. On those steps the micro-program counter jumps to the fetched opcode multiplied by 256.

The core connects to one word-addressed memory that holds both program and data. The memory must return read data in the same cycle as the address, and it must write on the clock edge when the write enable is high. The core leaves reset through its own microsequence, which clears the program counter and fetches word 0. From then on it runs until it reaches one of two conditions: an opcode with no microcode, or a divide or remainder by zero. Either condition raises the halt output and freezes all state.

Top module: `mp_acc_core`

## Requirements
- R1: After reset is released, halt and mem_we are low. The first instruction is fetched from address 0. In the third cycle after release, mem_addr is 0 and mem_wdata shows the word at address 0.
- R2: An instruction word holds the opcode in bits 31:24 and a memory address in bits 23:0. Opcodes 0x10 to 0x14 set ACC to ACC op M[addr], using unsigned 32-bit arithmetic in this order: add, subtract, multiply (low 32 bits), divide, remainder. Each fetch increments the program counter.
- R3: Opcodes 0x15 and 0x20 load ACC from M[addr]. Opcodes 0x16 and 0x17 clear ACC.
- R4: Opcode 0x21 writes ACC to M[addr] in exactly one cycle. In the cycle after the write, mem_we is low and mem_wdata and mem_addr are unchanged.
- R5: Opcode 0x40 continues execution at addr.
- R6: Opcode 0x41 continues at addr when ACC is zero. Otherwise it continues at the next word.
- R7: Opcode 0xBC sets ACC to M[ACC + addr].
- R8: An opcode without microcode (for example 0xBB) raises halt. After that, halt stays high, no write occurs, and mem_addr stays constant.
- R9: A divide or remainder whose memory operand is zero raises halt. The accumulator is not updated and no later instruction runs.
- R10: At most one bus driver is active per step. mem_wdata carries the bus, which reads zero in steps with no driver, such as the first reset step.
- R11: The sample loop program starts with 5 at address 0x100. It leaves 1 at address 0x100, leaves addresses 0x101 to 0x103 unchanged, and halts at address 0xE, which is reached only when ACC is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_addr | output | 24 | Word address, taken from the address register |
| mem_wdata | output | 32 | Current bus value, used as write data |
| mem_we | output | 1 | Memory write strobe |
| mem_rdata | input | 32 | Read data for mem_addr, valid in the same cycle |
| halt | output | 1 | Sticky stop indication |

## Verification
The hardest situations to reach are the two halt causes and the one-cycle hold of store data. A halt on division by zero happens only when an ALU step sees a zero operand on the bus, so the bench places a zero at the divisor address and puts a store behind the divide to show that it never runs. The hold after a write is seen only as the cycle that follows mem_we, so a port monitor compares consecutive cycles during every store that the vector table triggers.

// File: rtl/mp_pkg.sv
package mp_pkg;
  localparam int unsigned CW_W = 16;
  localparam int unsigned OPC_W = 8;

  // control word bit positions
  localparam int unsigned CB_ALU_LD = 4;
  localparam int unsigned CB_ACC_OE = 5;
  localparam int unsigned CB_MAR_LD = 6;
  localparam int unsigned CB_MEM_WE = 7;
  localparam int unsigned CB_MEM_OE = 8;
  localparam int unsigned CB_PC_OE = 11;
  localparam int unsigned CB_BR_ALW = 12;
  localparam int unsigned CB_BR_ZER = 13;
  localparam int unsigned CB_IMM_OE = 14;
  localparam int unsigned CB_NEXT = 15;

  // ALU function codes
  localparam logic [3:0] FN_ADD = 4'd0;
  localparam logic [3:0] FN_SUB = 4'd1;
  localparam logic [3:0] FN_MUL = 4'd2;
  localparam logic [3:0] FN_DIV = 4'd3;
  localparam logic [3:0] FN_REM = 4'd4;
  localparam logic [3:0] FN_PASS = 4'd5;
  localparam logic [3:0] FN_ZERO = 4'd6;
endpackage

// File: rtl/mp_ucode_rom.sv
module mp_ucode_rom #(
  parameter int unsigned UPC_W = 16
) (
  input  logic [UPC_W-1:0]        upc,
  output logic [mp_pkg::CW_W-1:0] word
);
  localparam int unsigned OP_W = mp_pkg::OPC_W;
  localparam int unsigned STEP_W = UPC_W - OP_W;

  function automatic logic [15:0] ustep(input logic [7:0] op, input int s);
    logic [15:0] w;
    w = 16'h0000;
    if (op == 8'h00) begin
      case (s)
        0: w = 16'h3000;
        1: w = 16'h0840;
        2: w = 16'h8100;
        default: w = 16'h0000;
      endcase
    end else if ((op >= 8'h10 && op <= 8'h17) || op == 8'h20) begin
      case (s)
        0: w = 16'h4040;
        1: begin
          if (op == 8'h20) w = 16'h0115;
          else if (op == 8'h17) w = 16'h0116;
          else w = {12'h011, op[3:0]};
        end
        2: w = 16'h0840;
        3: w = 16'h8100;
        default: w = 16'h0000;
      endcase
    end else if (op == 8'h21) begin
      case (s)
        0: w = 16'h4040;
        1: w = 16'h00a0;
        2: w = 16'h0020;
        3: w = 16'h0840;
        4: w = 16'h8100;
        default: w = 16'h0000;
      endcase
    end else if (op == 8'h40 || op == 8'h41) begin
      case (s)
        0: w = (op == 8'h40) ? 16'h5000 : 16'h6000;
        1: w = 16'h0840;
        2: w = 16'h8100;
        default: w = 16'h0000;
      endcase
    end else if (op == 8'hBC) begin
      case (s)
        0: w = 16'h4010;
        1: w = 16'h0060;
        2: w = 16'h0115;
        3: w = 16'h0840;
        4: w = 16'h8100;
        default: w = 16'h0000;
      endcase
    end
    return w;
  endfunction

  always_comb begin
    word = ustep(8'(upc[UPC_W-1 -: OP_W]), int'(upc[STEP_W-1:0]));
  end
endmodule

// File: rtl/mp_alu.sv
module mp_alu #(
  parameter int unsigned W = 32
) (
  input  logic [3:0]   func,
  input  logic [W-1:0] acc,
  input  logic [W-1:0] opnd,
  output logic [W-1:0] res,
  output logic         div_zero
);
  import mp_pkg::*;

  function automatic logic [W-1:0] alu_eval(input logic [3:0] f,
                                            input logic [W-1:0] a,
                                            input logic [W-1:0] b);
    logic [W-1:0] r;
    case (f)
      FN_ADD:  r = a + b;
      FN_SUB:  r = a - b;
      FN_MUL:  r = a * b;
      FN_DIV:  r = (b == '0) ? '0 : a / b;
      FN_REM:  r = (b == '0) ? '0 : a % b;
      FN_PASS: r = b;
      default: r = '0;
    endcase
    return r;
  endfunction

  always_comb begin
    res = alu_eval(func, acc, opnd);
    div_zero = ((func == FN_DIV) || (func == FN_REM)) && (opnd == '0);
  end
endmodule

// File: rtl/mp_pc_unit.sv
module mp_pc_unit #(
  parameter int unsigned AW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hold,
  input  logic          br_alw,
  input  logic          br_zer,
  input  logic          acc_zero,
  input  logic          next_ins,
  input  logic [AW-1:0] bus_addr,
  output logic [AW-1:0] pc_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q <= '0;
    end else if (!hold) begin
      if (br_alw && br_zer) pc_q <= '0;
      else if (br_alw) pc_q <= bus_addr;
      else if (br_zer && acc_zero) pc_q <= bus_addr;
      else if (next_ins) pc_q <= pc_q + AW'(1);
    end
  end
endmodule

// File: rtl/mp_acc_core.sv
module mp_acc_core #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned UPC_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              halt
);
  import mp_pkg::*;
  localparam int unsigned OP_W = OPC_W;
  localparam int unsigned IMM_W = DATA_W - OP_W;
  localparam int unsigned STEP_W = UPC_W - OP_W;

  logic [CW_W-1:0]   uword;
  logic [DATA_W-1:0] acc_q, bus, alu_res;
  logic [ADDR_W-1:0] mar_q, pc_q;
  logic [IMM_W-1:0]  imm_q;
  logic [UPC_W-1:0]  upc_q;
  logic              halt_q, div_zero;

  // named events for the checker
  logic [3:0] drv_vec;
  logic       fetch_ev, div0_ev, nomap_ev, fault_ev, hold;
  logic       unused_bits;

  mp_ucode_rom #(.UPC_W(UPC_W)) u_rom (.upc(upc_q), .word(uword));

  assign drv_vec = {uword[CB_IMM_OE], uword[CB_PC_OE], uword[CB_MEM_OE], uword[CB_ACC_OE]};
  assign unused_bits = ^uword[10:9];

  always_comb begin
    bus = '0;
    if (drv_vec[0]) bus = bus | acc_q;
    if (drv_vec[1]) bus = bus | mem_rdata;
    if (drv_vec[2]) bus = bus | DATA_W'(pc_q);
    if (drv_vec[3]) bus = bus | DATA_W'(imm_q);
  end

  mp_alu #(.W(DATA_W)) u_alu (
    .func(uword[3:0]), .acc(acc_q), .opnd(bus), .res(alu_res), .div_zero(div_zero)
  );

  assign div0_ev  = uword[CB_ALU_LD] & div_zero;
  assign nomap_ev = (uword == '0);
  assign fault_ev = ~halt_q & (div0_ev | nomap_ev);
  assign hold     = halt_q | div0_ev | nomap_ev;
  assign fetch_ev = uword[CB_NEXT] & ~hold;

  mp_pc_unit #(.AW(ADDR_W)) u_pc (
    .clk(clk), .rst_n(rst_n), .hold(hold),
    .br_alw(uword[CB_BR_ALW]), .br_zer(uword[CB_BR_ZER]),
    .acc_zero(acc_q == '0), .next_ins(uword[CB_NEXT]),
    .bus_addr(bus[ADDR_W-1:0]), .pc_q(pc_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q  <= '0;
      mar_q  <= '0;
      imm_q  <= '0;
      upc_q  <= '0;
      halt_q <= 1'b0;
    end else begin
      if (fault_ev) halt_q <= 1'b1;
      if (!hold) begin
        if (uword[CB_ALU_LD]) acc_q <= alu_res;
        if (uword[CB_MAR_LD]) mar_q <= bus[ADDR_W-1:0];
        if (uword[CB_NEXT]) begin
          imm_q <= mem_rdata[IMM_W-1:0];
          upc_q <= {mem_rdata[DATA_W-1 -: OP_W], {STEP_W{1'b0}}};
        end else begin
          upc_q <= upc_q + UPC_W'(1);
        end
      end
    end
  end

  assign mem_addr  = mar_q;
  assign mem_wdata = bus;
  assign mem_we    = uword[CB_MEM_WE] & ~halt_q;
  assign halt      = halt_q;
endmodule

// File: rtl/mp_acc_core_chk.sv
module mp_acc_core_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned UPC_W = 16,
  parameter int unsigned STEP_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              halt,
  input logic              mem_we,
  input logic [DATA_W-1:0] mem_wdata,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [3:0]        drv_vec,
  input logic              fetch_ev,
  input logic              div0_ev,
  input logic              acc_oe,
  input logic [ADDR_W-1:0] pc_q,
  input logic [UPC_W-1:0]  upc_q
);
  // R10
  one_driver_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(drv_vec));

  // R4
  store_src_chk: assert property (@(posedge clk) disable iff (!rst_n) mem_we |-> acc_oe);

  // R4
  store_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> (!mem_we && $stable(mem_wdata) && $stable(mem_addr)));

  // R8
  halt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> (halt && !mem_we && $stable(mem_addr)));

  // R9
  div_zero_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div0_ev |=> halt);

  // R2
  fetch_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_ev |=> ((upc_q[STEP_W-1:0] == '0) && (pc_q == $past(pc_q) + ADDR_W'(1))));
endmodule

bind mp_acc_core mp_acc_core_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .UPC_W(UPC_W), .STEP_W(STEP_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .halt(halt), .mem_we(mem_we), .mem_wdata(mem_wdata),
  .mem_addr(mem_addr), .drv_vec(drv_vec), .fetch_ev(fetch_ev), .div0_ev(div0_ev),
  .acc_oe(drv_vec[0]), .pc_q(pc_q), .upc_q(upc_q)
);

// File: tb/mp_acc_core_bench.sv
module mp_acc_core_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;
  logic        mem_we, halt;

  int checks = 0;
  int failures = 0;
  int wr_cnt = 0;
  int hold_bad = 0;
  logic        prev_we = 1'b0;
  logic [31:0] prev_wd = '0;
  logic [31:0] mem [512];

  localparam logic [31:0] SENT = 32'hDEAD_BEEF;
  localparam int NV = 8;
  // {opcode, first operand at 0x100, second operand at 0x101}
  localparam logic [71:0] VEC [NV] = '{
    {8'h10, 32'hFFFF_FFFF, 32'h0000_0002},
    {8'h11, 32'h0000_0003, 32'h0000_0005},
    {8'h12, 32'h0001_0000, 32'h0001_0003},
    {8'h13, 32'd100,       32'd7},
    {8'h14, 32'd100,       32'd7},
    {8'h15, 32'd9,         32'h0000_1234},
    {8'h16, 32'd9,         32'd4},
    {8'h17, 32'd9,         32'd4}
  };

  always #2.5 clk = ~clk;

  mp_acc_core u_mp_acc_core (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_rdata(mem_rdata), .halt(halt)
  );

  assign mem_rdata = mem[mem_addr[8:0]];
  always @(posedge clk) if (mem_we) mem[mem_addr[8:0]] <= mem_wdata;

  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_we && (mem_we || mem_wdata != prev_wd)) hold_bad++;
      if (mem_we) wr_cnt++;
      prev_we = mem_we;
      prev_wd = mem_wdata;
    end else begin
      prev_we = 1'b0;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 512; i++) mem[i] = 32'h0;
    mem[9'h110] = SENT;
    mem[9'h111] = SENT;
  endtask

  task automatic run_prog(input int limit);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    wr_cnt = 0;
    hold_bad = 0;
    rst_n = 1'b1;
    for (int c = 0; c < limit; c++) begin
      @(negedge clk);
      if (halt) break;
    end
  endtask

  function automatic logic [31:0] model_op(input logic [7:0] op, input logic [31:0] a,
                                           input logic [31:0] b);
    logic [63:0] p;
    case (op)
      8'h10: return a + b;
      8'h11: return a + ~b + 32'd1;
      8'h12: begin p = {32'h0, a} * {32'h0, b}; return p[31:0]; end
      8'h13: return a / b;
      8'h14: return a - (a / b) * b;
      8'h15: return b;
      default: return 32'h0;
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired, run did not end");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] exp, x;
    logic [23:0] a_hold;
    int w_hold;
    bit halt_stay;

    // R1 / R10: reset state and first fetch
    clear_mem();
    mem[0] = 32'hBB00_0000;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(!halt && !mem_we, "R1 reset outputs", {30'h0, halt, mem_we}, 32'h0);
    check(mem_addr == 24'h0, "R1 reset address", {8'h0, mem_addr}, 32'h0);
    check(mem_wdata == 32'h0, "R10 undriven bus", mem_wdata, 32'h0);
    rst_n = 1'b1;
    #1;
    check(mem_wdata == 32'h0, "R10 bus in step 0", mem_wdata, 32'h0);
    @(negedge clk);
    @(negedge clk);
    check(mem_addr == 24'h0 && mem_wdata == 32'hBB00_0000, "R1 fetch from 0",
          mem_wdata, 32'hBB00_0000);
    repeat (4) @(negedge clk);
    check(halt == 1'b1, "R8 no-microcode opcode halts", {31'h0, halt}, 32'h1);

    // R2 / R3 / R4: table of ALU vectors, each followed by a store
    for (int v = 0; v < NV; v++) begin
      clear_mem();
      mem[0] = 32'h2000_0100;
      mem[1] = {VEC[v][71:64], 24'h000101};
      mem[2] = 32'h2100_0110;
      mem[3] = 32'hBB00_0000;
      mem[9'h100] = VEC[v][63:32];
      mem[9'h101] = VEC[v][31:0];
      exp = model_op(VEC[v][71:64], VEC[v][63:32], VEC[v][31:0]);
      run_prog(200);
      check(mem[9'h110] == exp, (VEC[v][71:64] <= 8'h14) ? "R2 alu result" : "R3 load/clear",
            mem[9'h110], exp);
      check(wr_cnt == 1 && hold_bad == 0, "R4 single write with held data",
            32'(wr_cnt * 16 + hold_bad), 32'h10);
    end

    // R5: unconditional jump skips words 1 and 2
    clear_mem();
    mem[0] = 32'h4000_0003;
    mem[1] = 32'h2000_0101;
    mem[2] = 32'h2100_0111;
    mem[3] = 32'h2000_0100;
    mem[4] = 32'h2100_0110;
    mem[5] = 32'hBB00_0000;
    mem[9'h100] = 32'd9;
    mem[9'h101] = 32'd7;
    run_prog(200);
    check(mem[9'h110] == 32'd9, "R5 jump target ran", mem[9'h110], 32'd9);
    check(mem[9'h111] == SENT, "R5 skipped store", mem[9'h111], SENT);

    // R6: branch on zero taken
    clear_mem();
    mem[0] = 32'h1600_0000;
    mem[1] = 32'h4100_0003;
    mem[2] = 32'h2100_0111;
    mem[3] = 32'h2000_0100;
    mem[4] = 32'h2100_0110;
    mem[5] = 32'hBB00_0000;
    mem[9'h100] = 32'd11;
    run_prog(200);
    check(mem[9'h111] == SENT && mem[9'h110] == 32'd11, "R6 taken branch",
          mem[9'h111], SENT);

    // R6: branch on zero not taken
    clear_mem();
    mem[0] = 32'h2000_0100;
    mem[1] = 32'h4100_0004;
    mem[2] = 32'h2100_0111;
    mem[3] = 32'hBB00_0000;
    mem[4] = 32'hBB00_0000;
    mem[9'h100] = 32'd9;
    run_prog(200);
    check(mem[9'h111] == 32'd9, "R6 fall through", mem[9'h111], 32'd9);

    // R7: indexed load M[ACC + addr]
    clear_mem();
    mem[0] = 32'h2000_0100;
    mem[1] = 32'hBC00_0120;
    mem[2] = 32'h2100_0110;
    mem[3] = 32'hBB00_0000;
    mem[9'h100] = 32'd3;
    mem[9'h123] = 32'h0000_0055;
    run_prog(200);
    check(mem[9'h110] == 32'h55, "R7 indexed load", mem[9'h110], 32'h55);

    // R9: divide by zero stops before the store
    clear_mem();
    mem[0] = 32'h2000_0100;
    mem[1] = 32'h1300_0101;
    mem[2] = 32'h2100_0110;
    mem[3] = 32'h4000_0000;
    mem[9'h100] = 32'd7;
    mem[9'h101] = 32'd0;
    run_prog(200);
    check(halt == 1'b1, "R9 halt on divide by zero", {31'h0, halt}, 32'h1);
    check(mem[9'h110] == SENT && wr_cnt == 0, "R9 no later store", mem[9'h110], SENT);

    // R8: frozen after halt
    a_hold = mem_addr;
    w_hold = wr_cnt;
    halt_stay = 1'b1;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (!halt || mem_addr != a_hold) halt_stay = 1'b0;
    end
    check(halt_stay && wr_cnt == w_hold, "R8 state frozen", {8'h0, mem_addr}, {8'h0, a_hold});

    // R11: sample loop program
    clear_mem();
    mem[0]  = 32'h2000_0100;
    mem[1]  = 32'h1400_0102;
    mem[2]  = 32'h4100_0008;
    mem[3]  = 32'h2000_0100;
    mem[4]  = 32'h1200_0103;
    mem[5]  = 32'h1000_0101;
    mem[6]  = 32'h2100_0100;
    mem[7]  = 32'h4000_0001;
    mem[8]  = 32'h2000_0100;
    mem[9]  = 32'h1300_0102;
    mem[10] = 32'h2100_0100;
    mem[11] = 32'h1100_0101;
    mem[12] = 32'h4100_000E;
    mem[13] = 32'h4000_0000;
    mem[14] = 32'hBBBB_BBBB;
    mem[9'h100] = 32'd5;
    mem[9'h101] = 32'd1;
    mem[9'h102] = 32'd2;
    mem[9'h103] = 32'd3;
    x = 32'd5;
    for (int it = 0; it < 1000; it++) begin
      if (x[0]) x = 3 * x + 1;
      else begin
        x = x >> 1;
        if (x == 32'd1) break;
      end
    end
    run_prog(5000);
    check(halt == 1'b1, "R11 program halts", {31'h0, halt}, 32'h1);
    check(mem[9'h100] == x, "R11 final value", mem[9'h100], x);
    check(mem[9'h101] == 32'd1 && mem[9'h102] == 32'd2 && mem[9'h103] == 32'd3,
          "R11 constants intact", mem[9'h103], 32'd3);
    check(mem_addr == 24'h00000E, "R11 stop word reached only with ACC zero",
          {8'h0, mem_addr}, 32'hE);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule